// File: doc/BRIEF.md
# Buffered Input Capture Channel

This block is one timer input-capture channel with a two-deep capture queue. A free-running counter, which can optionally clear on a compare value, is sampled whenever a selected transition appears on a synchronized input level. The newest timestamp sits in a capture register. The one before it sits in a holding register. An interrupt flag marks that both registers hold fresh data.

Software enables the channel by writing a nonzero edge mode. That write marks both registers empty. The first selected edge after the write fills the capture register and leaves the flag alone. Each later edge pushes the capture register into the holding register, stores the new timestamp and raises the flag.

A no-overwrite option freezes the pair once both are full. It keeps them frozen until software has read each of them. Empty/full state is tracked per register, so reads and a flag clear may come in any order. An edge landing between or together with them never stops later edges from raising the flag.

Top module: `icq_channel`

## Requirements
- R1: While reset is held low, the counter, both captured values and the flag read zero.
- R2: With modulus clearing off, or with a compare value of zero, the counter advances by one every clock and wraps from all ones to zero.
- R3: With modulus clearing on and a nonzero compare value, the counter reaches the compare value, shows it for exactly one clock, and reads zero on the next clock.
- R4: The edge mode code 00 disables capture, 01 selects low-to-high transitions, 10 selects high-to-low transitions and 11 selects both. A transition is seen when the input level sampled in a clock differs from the level sampled in the previous clock in a selected direction. An accepted edge stores the counter value of that same clock.
- R5: A mode write with a nonzero code marks both registers empty and releases the no-overwrite lock, and an edge in the write's own clock is ignored. A write of 00 stops capture from the next clock without emptying anything.
- R6: An accepted edge while the capture register is empty stores into the capture register only and does not raise the flag.
- R7: An accepted edge while the capture register is full copies the old capture value into the holding register, stores the new timestamp, and raises the flag one clock later.
- R8: With no-overwrite on, once both registers have become full, edges change neither register nor the flag. This lasts until the capture register and the holding register have each been read; reading only one of them is not enough.
- R9: With no-overwrite off, every accepted edge is stored, and the oldest value is discarded from the holding register.
- R10: A flag-clear strobe clears the flag one clock later, unless an edge pushes into the holding register in that same clock, in which case the flag stays set.
- R11: For every order of capture read, holding read and flag clear, and for an edge placed before, between or after them, a full service leaves the channel ready: the next two edges raise the flag and show both timestamps.
- R12: A read strobe in the same clock as a store into that register leaves the register full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_en | input | 1 | Enables modulus clearing of the counter |
| mod_cmp | input | W | Compare value at which the counter clears |
| cnt_o | output | W | Free-running counter value |
| pin_i | input | 1 | Synchronized input level watched for edges |
| mode_wr | input | 1 | Strobe that writes the edge mode |
| mode_wdata | input | 2 | Edge mode code to write |
| nov_i | input | 1 | No-overwrite option |
| rd_cap | input | 1 | Strobe marking a read of the capture register |
| rd_hold | input | 1 | Strobe marking a read of the holding register |
| flag_clr | input | 1 | Strobe clearing the interrupt flag |
| cap_o | output | W | Capture register (newest timestamp) |
| hold_o | output | W | Holding register (previous timestamp) |
| flag_o | output | 1 | Interrupt flag |

## Verification
The capture path is driven with low-to-high, high-to-low and both-direction edge trains. This separates a correct mode decode from one that mixes up directions or ignores the disable code. Two- and three-edge trains with no-overwrite off tell the first-edge, push and discard paths apart by the exact timestamps that land in each register.

The servicing race is swept over all six orders of the two reads and the flag clear, with an edge placed in each of the four gaps. A lock that releases too early, or never, shows up as a wrong capture value or a missing flag afterwards. Same-clock collisions of an edge with a read, a flag clear or a mode write check that stored data wins over emptying. The counter is run through its natural wrap and through a short modulus period to confirm the one-clock dwell on the compare value.

// File: rtl/icq_pkg.sv
package icq_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  // Decide whether a level change between two samples is a selected edge.
  function automatic logic edge_seen(edge_mode_e mode, logic prev, logic cur);
    logic went_up;
    logic went_down;
    went_up   = cur & ~prev;
    went_down = ~cur & prev;
    case (mode)
      EDGE_RISE: edge_seen = went_up;
      EDGE_FALL: edge_seen = went_down;
      EDGE_ANY:  edge_seen = went_up | went_down;
      default:   edge_seen = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/icq_counter.sv
module icq_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mod_en,
  input  logic [W-1:0] mod_cmp,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // Next counter value: clear after dwelling on a nonzero compare value.
  function automatic logic [W-1:0] next_count(logic [W-1:0] cur, logic en,
                                              logic [W-1:0] cmp);
    if (en && (cmp != '0) && (cur == cmp)) next_count = '0;
    else                                    next_count = cur + ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_count(cnt, mod_en, mod_cmp);
  end

endmodule

// File: rtl/icq_edge.sv
module icq_edge
  import icq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  output logic       edge_hit,
  output logic       arm
);

  edge_mode_e mode_q;
  logic       prev_q;

  // A nonzero mode write re-arms the channel in this clock.
  assign arm      = mode_wr && (edge_mode_e'(mode_wdata) != EDGE_OFF);
  assign edge_hit = edge_seen(mode_q, prev_q, pin_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= EDGE_OFF;
      prev_q <= 1'b0;
    end else begin
      prev_q <= pin_i;
      if (mode_wr) mode_q <= edge_mode_e'(mode_wdata);
    end
  end

endmodule

// File: rtl/icq_store.sv
module icq_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         edge_hit,
  input  logic         arm,
  input  logic         nov_i,
  input  logic [W-1:0] cnt,
  input  logic         rd_cap,
  input  logic         rd_hold,
  input  logic         flag_clr,
  output logic [W-1:0] cap_q,
  output logic [W-1:0] hold_q,
  output logic         cap_full,
  output logic         hold_full,
  output logic         lock,
  output logic         flag,
  output logic         edge_take,
  output logic         push_hold
);

  logic cap_full_n;
  logic hold_full_n;
  logic lock_n;

  assign edge_take = edge_hit && !arm && (!nov_i || !lock);
  assign push_hold = edge_take && cap_full;

  // Stores win over read strobes; a re-arm empties everything.
  always_comb begin
    if (arm)            cap_full_n = 1'b0;
    else if (edge_take) cap_full_n = 1'b1;
    else if (rd_cap)    cap_full_n = 1'b0;
    else                cap_full_n = cap_full;

    if (arm)            hold_full_n = 1'b0;
    else if (push_hold) hold_full_n = 1'b1;
    else if (rd_hold)   hold_full_n = 1'b0;
    else                hold_full_n = hold_full;

    if (arm)                            lock_n = 1'b0;
    else if (cap_full_n && hold_full_n) lock_n = 1'b1;
    else if (!cap_full_n && !hold_full_n) lock_n = 1'b0;
    else                                lock_n = lock;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q     <= '0;
      hold_q    <= '0;
      cap_full  <= 1'b0;
      hold_full <= 1'b0;
      lock      <= 1'b0;
      flag      <= 1'b0;
    end else begin
      cap_full  <= cap_full_n;
      hold_full <= hold_full_n;
      lock      <= lock_n;
      if (edge_take) cap_q  <= cnt;
      if (push_hold) hold_q <= cap_q;
      if (push_hold)     flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

endmodule

// File: rtl/icq_channel.sv
module icq_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mod_en,
  input  logic [W-1:0] mod_cmp,
  output logic [W-1:0] cnt_o,
  input  logic         pin_i,
  input  logic         mode_wr,
  input  logic [1:0]   mode_wdata,
  input  logic         nov_i,
  input  logic         rd_cap,
  input  logic         rd_hold,
  input  logic         flag_clr,
  output logic [W-1:0] cap_o,
  output logic [W-1:0] hold_o,
  output logic         flag_o
);

  // Internal events brought out by name for the checker.
  logic edge_hit;
  logic arm;
  logic edge_take;
  logic push_hold;
  logic cap_full;
  logic hold_full;
  logic lock;

  icq_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .mod_en  (mod_en),
    .mod_cmp (mod_cmp),
    .cnt     (cnt_o)
  );

  icq_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pin_i),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .edge_hit   (edge_hit),
    .arm        (arm)
  );

  icq_store #(.W(W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_hit  (edge_hit),
    .arm       (arm),
    .nov_i     (nov_i),
    .cnt       (cnt_o),
    .rd_cap    (rd_cap),
    .rd_hold   (rd_hold),
    .flag_clr  (flag_clr),
    .cap_q     (cap_o),
    .hold_q    (hold_o),
    .cap_full  (cap_full),
    .hold_full (hold_full),
    .lock      (lock),
    .flag      (flag_o),
    .edge_take (edge_take),
    .push_hold (push_hold)
  );

endmodule

// File: rtl/icq_channel_chk.sv
module icq_channel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mod_en,
  input logic [W-1:0] mod_cmp,
  input logic [W-1:0] cnt_o,
  input logic [W-1:0] cap_o,
  input logic [W-1:0] hold_o,
  input logic         flag_o,
  input logic         flag_clr,
  input logic         rd_cap,
  input logic         nov_i,
  input logic         edge_hit,
  input logic         edge_take,
  input logic         push_hold,
  input logic         arm,
  input logic         cap_full,
  input logic         hold_full,
  input logic         lock
);

  // R2
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> cnt_o == ($past(cnt_o) + 1'b1));

  // R3
  modulus_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && mod_cmp != '0 && cnt_o == mod_cmp) |=> cnt_o == '0);

  // R4
  capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_take |=> cap_o == $past(cnt_o));

  // R5
  arm_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!cap_full && !hold_full && !lock));

  // R6
  first_edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_take && !cap_full && !flag_o) |=> !flag_o);

  // R7
  push_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_hold |=> (flag_o && hold_o == $past(cap_o)));

  // R8
  locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nov_i && lock && edge_hit) |=> ($stable(cap_o) && $stable(hold_o)));

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !push_hold) |=> !flag_o);

  // R12
  store_beats_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_take && rd_cap) |=> cap_full);

endmodule

bind icq_channel icq_channel_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mod_en    (mod_en),
  .mod_cmp   (mod_cmp),
  .cnt_o     (cnt_o),
  .cap_o     (cap_o),
  .hold_o    (hold_o),
  .flag_o    (flag_o),
  .flag_clr  (flag_clr),
  .rd_cap    (rd_cap),
  .nov_i     (nov_i),
  .edge_hit  (edge_hit),
  .edge_take (edge_take),
  .push_hold (push_hold),
  .arm       (arm),
  .cap_full  (cap_full),
  .hold_full (hold_full),
  .lock      (lock)
);

// File: tb/icq_channel_test.sv
module icq_channel_test;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mod_en = 1'b0;
  logic [CW-1:0] mod_cmp = '0;
  logic [CW-1:0] cnt_o;
  logic          pin_i = 1'b0;
  logic          mode_wr = 1'b0;
  logic [1:0]    mode_wdata = 2'b00;
  logic          nov_i = 1'b0;
  logic          rd_cap = 1'b0;
  logic          rd_hold = 1'b0;
  logic          flag_clr = 1'b0;
  logic [CW-1:0] cap_o;
  logic [CW-1:0] hold_o;
  logic          flag_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icq_channel #(.W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .mod_cmp(mod_cmp), .cnt_o(cnt_o),
    .pin_i(pin_i), .mode_wr(mode_wr), .mode_wdata(mode_wdata), .nov_i(nov_i),
    .rd_cap(rd_cap), .rd_hold(rd_hold), .flag_clr(flag_clr),
    .cap_o(cap_o), .hold_o(hold_o), .flag_o(flag_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_wr = 1'b1; mode_wdata = m;
    tick();
    mode_wr = 1'b0;
  endtask

  // op: 0 = capture read, 1 = holding read, 2 = flag clear
  task automatic strobe(input int op);
    rd_cap = (op == 0); rd_hold = (op == 1); flag_clr = (op == 2);
    tick();
    rd_cap = 1'b0; rd_hold = 1'b0; flag_clr = 1'b0;
  endtask

  // Drive the input to 'lvl' through a real transition, with optional strobes
  // in the transition clock; returns the counter value of that clock.
  task automatic make_edge(input logic lvl, input logic rc, input logic fc,
                           input logic mw, output logic [CW-1:0] stamp);
    if (pin_i == lvl) begin
      pin_i = ~lvl;
      tick();
    end
    pin_i = lvl; rd_cap = rc; flag_clr = fc;
    if (mw) begin mode_wr = 1'b1; mode_wdata = 2'b01; end
    stamp = cnt_o;
    tick();
    rd_cap = 1'b0; flag_clr = 1'b0; mode_wr = 1'b0;
  endtask

  task automatic rise(output logic [CW-1:0] stamp);
    make_edge(1'b1, 1'b0, 1'b0, 1'b0, stamp);
  endtask

  task automatic toggle(output logic [CW-1:0] stamp);
    pin_i = ~pin_i;
    stamp = cnt_o;
    tick();
  endtask

  task automatic t_reset();
    chk("R1", "cnt in reset", cnt_o, 0);
    chk("R1", "cap in reset", cap_o, 0);
    chk("R1", "hold in reset", hold_o, 0);
    chk("R1", "flag in reset", flag_o, 0);
  endtask

  task automatic t_counter();
    logic [CW-1:0] c0;
    c0 = cnt_o;
    repeat (5) tick();
    chk("R2", "count advance", cnt_o, CW'(c0 + 5));
    for (int i = 0; i < 300 && cnt_o != '1; i++) tick();
    tick();
    chk("R2", "wrap to zero", cnt_o, 0);
    mod_en = 1'b1; mod_cmp = 8'd5;
    for (int i = 0; i < 300 && cnt_o != 8'd5; i++) tick();
    chk("R3", "reach compare", cnt_o, 5);
    tick();
    chk("R3", "clear after one clock", cnt_o, 0);
    tick();
    chk("R3", "restart at one", cnt_o, 1);
    repeat (4) tick();
    chk("R3", "second period top", cnt_o, 5);
    tick();
    chk("R3", "second period clear", cnt_o, 0);
    mod_cmp = '0;
    repeat (7) tick();
    chk("R2", "compare zero free runs", cnt_o, 7);
    mod_en = 1'b0;
  endtask

  task automatic t_basic();
    logic [CW-1:0] s1, s2, s3;
    set_mode(2'b01);
    strobe(2);
    rise(s1);
    chk("R6", "first edge cap", cap_o, s1);
    chk("R6", "first edge flag", flag_o, 0);
    rise(s2);
    chk("R7", "second edge cap", cap_o, s2);
    chk("R7", "second edge hold", hold_o, s1);
    chk("R7", "second edge flag", flag_o, 1);
    strobe(2);
    chk("R10", "flag cleared", flag_o, 0);
    make_edge(1'b1, 1'b0, 1'b1, 1'b0, s3);
    chk("R10", "clear with push keeps flag", flag_o, 1);
    chk("R9", "third edge hold", hold_o, s2);
    chk("R9", "third edge cap", cap_o, s3);
    strobe(2);
  endtask

  task automatic t_modes();
    logic [CW-1:0] s1, s2, keep;
    pin_i = 1'b0; tick();
    set_mode(2'b10);
    keep = cap_o;
    make_edge(1'b1, 1'b0, 1'b0, 1'b0, s1);
    chk("R4", "fall mode ignores rise", cap_o, keep);
    make_edge(1'b0, 1'b0, 1'b0, 1'b0, s1);
    chk("R4", "fall mode captures fall", cap_o, s1);
    chk("R4", "fall first edge no flag", flag_o, 0);
    set_mode(2'b11);
    toggle(s1);
    toggle(s2);
    chk("R4", "any mode hold", hold_o, s1);
    chk("R4", "any mode cap", cap_o, s2);
    chk("R4", "any mode flag", flag_o, 1);
    strobe(2);
    set_mode(2'b00);
    keep = cap_o;
    toggle(s1);
    toggle(s1);
    chk("R5", "mode 00 ignores edges", cap_o, keep);
    chk("R5", "mode 00 no flag", flag_o, 0);
    set_mode(2'b01);
    keep = cap_o;
    make_edge(1'b1, 1'b0, 1'b0, 1'b1, s1);
    chk("R5", "edge in arm clock ignored", cap_o, keep);
    rise(s1);
    chk("R5", "after arm first edge cap", cap_o, s1);
    chk("R5", "after arm first edge no flag", flag_o, 0);
  endtask

  task automatic t_nov();
    logic [CW-1:0] s1, s2, s3, k1, k2;
    nov_i = 1'b1;
    set_mode(2'b01);
    strobe(2);
    rise(s1);
    rise(s2);
    strobe(2);
    k1 = cap_o; k2 = hold_o;
    rise(s3);
    chk("R8", "locked cap frozen", cap_o, k1);
    chk("R8", "locked hold frozen", hold_o, k2);
    chk("R8", "locked no flag", flag_o, 0);
    strobe(0);
    rise(s3);
    chk("R8", "cap read alone keeps lock", cap_o, k1);
    strobe(1);
    rise(s3);
    chk("R8", "both read resumes", cap_o, s3);
    chk("R8", "resume no flag", flag_o, 0);
    nov_i = 1'b0;
    set_mode(2'b01);
    make_edge(1'b1, 1'b1, 1'b0, 1'b0, s1);
    rise(s2);
    chk("R12", "read with store keeps full", flag_o, 1);
    chk("R12", "hold after collision", hold_o, s1);
    strobe(2);
  endtask

  task automatic t_race();
    int ord[3];
    int last_rd;
    logic [CW-1:0] s1, s2, e, snap, f1, f2;
    nov_i = 1'b1;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++) begin
          if (a == b || a == c || b == c) continue;
          ord[0] = a; ord[1] = b; ord[2] = c;
          last_rd = (ord[2] != 2) ? 2 : 1;
          for (int p = 0; p < 4; p++) begin
            set_mode(2'b01);
            strobe(2);
            rise(s1);
            rise(s2);
            for (int i = 0; i < 4; i++) begin
              if (i == p) begin
                snap = cap_o;
                rise(e);
                if (p <= last_rd) chk("R11", "edge while locked", cap_o, snap);
                else              chk("R11", "edge after reads", cap_o, e);
              end
              if (i < 3) strobe(ord[i]);
            end
            strobe(0);
            strobe(1);
            strobe(2);
            rise(f1);
            rise(f2);
            chk("R11", "flag after service", flag_o, 1);
            chk("R11", "cap after service", cap_o, f2);
            chk("R11", "hold after service", hold_o, f1);
          end
        end
    nov_i = 1'b0;
    strobe(2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    t_counter();
    t_basic();
    t_modes();
    t_nov();
    t_race();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule